// File: doc/BRIEF.md
# Indirect Register Window with Auto-Advancing Pointer

This block is the host side of a bus-interface controller's register set. The host reaches all of it through two ports. An address port loads a 5-bit pointer. A data port reads or writes the register that the pointer selects. After most accesses the pointer steps to the next register, so the host can stream through a run of registers after a single address load.

The block holds a 32-entry byte register file and a 24-bit transfer count. The count is spread over three adjacent byte addresses and is also presented whole to the command engine. Writes to the command register are not stored. They leave as a one-cycle strobe that carries the byte. Accesses to the data register pass straight through to the engine. A side-effect-free peek port lets debug logic see the status register or the addressed register without moving the pointer. Host strobes are plain single-cycle controls with no back-pressure: an access is taken in the cycle its strobe is high. Read data is combinational from the current pointer in that same cycle.

Top module: `ixw_top`

## Requirements
- R1: An address-port write loads the pointer with bits [4:0] of `addr_wdata`; bits [7:5] are dropped. If an address write and a data access share a cycle, the data access uses the old pointer and the pointer then takes the new address.
- R2: After a data-port write, the pointer steps by one, modulo 32. It stays put when the write targeted 0x18 (command), 0x19 (data) or 0x1F (status).
- R3: After a data-port read, the pointer steps by one, modulo 32. It stays put when the pointer was at 0x18, 0x19 or 0x1F. If `dat_we` and `dat_re` are both high, only the write is taken.
- R4: Addresses 0x12, 0x13 and 0x14 are bytes [23:16], [15:8] and [7:0] of the transfer count. A write changes only its own byte, a read returns only its own byte, and `tc_value` shows the whole count.
- R5: A write at 0x00–0x11, 0x15 or 0x16 is stored. A write at 0x17, 0x1A–0x1E or 0x1F leaves the read-back value unchanged.
- R6: A write at 0x00 sets `own_id` to bits [2:0] of the written byte, visible the cycle after the write.
- R7: After reset, the following hold:
  - 0x00–0x1A read 0x00, except the pass-through data register 0x19.
  - 0x1B–0x1E read 0xFF.
  - 0x1F (status) reads 0x80.
  - The pointer, `own_id` and the count are zero.
  - No strobe is active.
- R8: A write at 0x18 raises `cmd_stb` for exactly one cycle, starting the cycle after the write, with `cmd_byte` equal to the written byte. Reading 0x18 still returns its reset value of 0x00.
- R9: A write at 0x19 raises `xfer_wr_stb` in the same cycle with `xfer_wdata` equal to the byte. A read at 0x19 raises `xfer_rd_stb` in the same cycle and returns `xfer_rdata`. No other address raises these strobes.
- R10: `peek_data` returns the status register when `peek_sel` is 0 and the addressed value when it is 1. Peeking never moves the pointer and never raises a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_we | input | 1 | Address-port write strobe |
| addr_wdata | input | 8 | Address-port write byte (low 5 bits used) |
| dat_we | input | 1 | Data-port write strobe |
| dat_re | input | 1 | Data-port read strobe |
| dat_wdata | input | 8 | Data-port write byte |
| dat_rdata | output | 8 | Data-port read byte at the current pointer |
| peek_sel | input | 1 | Peek select: 0 status, 1 addressed register |
| peek_data | output | 8 | Side-effect-free view |
| own_id | output | 3 | Controller's own bus ID |
| tc_value | output | 24 | Whole transfer count |
| cmd_stb | output | 1 | Command byte written (one cycle) |
| cmd_byte | output | 8 | Last command byte |
| xfer_wr_stb | output | 1 | Data-register write pass-through |
| xfer_wdata | output | 8 | Byte passed to the engine |
| xfer_rd_stb | output | 1 | Data-register read pass-through |
| xfer_rdata | input | 8 | Byte supplied by the engine |

## Verification
Read data, `peek_data` and both pass-through strobes depend combinationally on the current pointer and strobes. The bench therefore checks them 1 ns after driving the inputs on a falling edge, in the same cycle. Register contents, the pointer, `own_id` and `tc_value` change on the rising edge that takes the access, and `cmd_stb` is a register stage. All of these are checked at the next falling edge, and `cmd_stb` is checked low again one cycle later. A bench model of the pointer, file and count predicts every value. It is exercised by directed corner cases and by seeded random mixes of address, write, read and peek operations.

// File: rtl/ixw_pkg.sv
`timescale 1ns/1ps
package ixw_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 5;
  localparam int NREG   = 1 << PTR_W;

  localparam logic [PTR_W-1:0] A_OWN    = 5'h00;
  localparam logic [PTR_W-1:0] A_TC_HI  = 5'h12;
  localparam logic [PTR_W-1:0] A_TC_LO  = 5'h14;
  localparam logic [PTR_W-1:0] A_GEN_MX = 5'h16;
  localparam logic [PTR_W-1:0] A_CMD    = 5'h18;
  localparam logic [PTR_W-1:0] A_DATA   = 5'h19;
  localparam logic [PTR_W-1:0] A_FILL0  = 5'h1B;
  localparam logic [PTR_W-1:0] A_FILL1  = 5'h1E;
  localparam logic [PTR_W-1:0] A_STAT   = 5'h1F;

  localparam logic [BYTE_W-1:0] STAT_RST = 8'h80;
  localparam logic [BYTE_W-1:0] FILL_RST = 8'hFF;

  // pointer does not move after an access at these addresses
  function automatic logic ptr_holds(input logic [PTR_W-1:0] a);
    return (a == A_CMD) || (a == A_DATA) || (a == A_STAT);
  endfunction

  function automatic logic in_tc(input logic [PTR_W-1:0] a);
    return (a >= A_TC_HI) && (a <= A_TC_LO);
  endfunction

  function automatic logic [BYTE_W-1:0] reset_byte(input int idx);
    if (idx == int'(A_STAT)) return STAT_RST;
    if (idx >= int'(A_FILL0) && idx <= int'(A_FILL1)) return FILL_RST;
    return '0;
  endfunction
endpackage

// File: rtl/ixw_ptr.sv
`timescale 1ns/1ps
module ixw_ptr #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic          step,
  output logic [PW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/ixw_regfile.sv
`timescale 1ns/1ps
module ixw_regfile
  import ixw_pkg::*;
#(
  parameter int N  = 32,
  parameter int W  = 8,
  localparam int AW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                         q[i] <= W'(reset_byte(i));
      else if (we && waddr == AW'(i))     q[i] <= wdata;
    end
  end
endmodule

// File: rtl/ixw_tcount.sv
`timescale 1ns/1ps
module ixw_tcount #(
  parameter int NB = 3,
  parameter int W  = 8,
  localparam int LW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [LW-1:0] lane,   // 0 = most significant byte
  input  logic [W-1:0]  wdata,
  output logic [NB*W-1:0] value
);
  for (genvar k = 0; k < NB; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)                       value[(NB-1-k)*W +: W] <= '0;
      else if (we && lane == LW'(k))    value[(NB-1-k)*W +: W] <= wdata;
    end
  end
endmodule

// File: rtl/ixw_top.sv
`timescale 1ns/1ps
module ixw_top
  import ixw_pkg::*;
#(
  parameter int TC_BYTES = 3,
  localparam int LW = (TC_BYTES > 1) ? $clog2(TC_BYTES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      addr_we,
  input  logic [BYTE_W-1:0]         addr_wdata,
  input  logic                      dat_we,
  input  logic                      dat_re,
  input  logic [BYTE_W-1:0]         dat_wdata,
  output logic [BYTE_W-1:0]         dat_rdata,
  input  logic                      peek_sel,
  output logic [BYTE_W-1:0]         peek_data,
  output logic [2:0]                own_id,
  output logic [TC_BYTES*BYTE_W-1:0] tc_value,
  output logic                      cmd_stb,
  output logic [BYTE_W-1:0]         cmd_byte,
  output logic                      xfer_wr_stb,
  output logic [BYTE_W-1:0]         xfer_wdata,
  output logic                      xfer_rd_stb,
  input  logic [BYTE_W-1:0]         xfer_rdata
);
  logic [PTR_W-1:0]              lat_q;
  logic [NREG-1:0][BYTE_W-1:0]   regs;
  logic                          rd_take, acc, step;
  logic                          gen_we, tc_we;
  logic [PTR_W-1:0]              lane_off;
  logic [LW-1:0]                 lane;
  logic [BYTE_W-1:0]             win_val;
  logic                          unused_hi;

  assign unused_hi = ^addr_wdata[BYTE_W-1:PTR_W];

  // a write wins over a read in the same cycle
  assign rd_take = dat_re && !dat_we;
  assign acc     = dat_we || rd_take;
  assign step    = acc && !ptr_holds(lat_q);

  ixw_ptr #(.PW(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(addr_we), .load_val(addr_wdata[PTR_W-1:0]),
    .step(step), .ptr(lat_q)
  );

  assign lane_off = lat_q - A_TC_HI;
  assign lane     = lane_off[LW-1:0];
  assign tc_we    = dat_we && in_tc(lat_q);
  assign gen_we   = dat_we && (lat_q <= A_GEN_MX) && !in_tc(lat_q);

  ixw_regfile #(.N(NREG), .W(BYTE_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(gen_we), .waddr(lat_q), .wdata(dat_wdata), .q(regs)
  );

  ixw_tcount #(.NB(TC_BYTES), .W(BYTE_W)) u_tc (
    .clk(clk), .rst_n(rst_n),
    .we(tc_we), .lane(lane), .wdata(dat_wdata), .value(tc_value)
  );

  always_comb begin
    if (in_tc(lat_q))
      win_val = tc_value[(TC_BYTES-1-int'(lane))*BYTE_W +: BYTE_W];
    else if (lat_q == A_DATA)
      win_val = xfer_rdata;
    else
      win_val = regs[lat_q];
  end

  assign dat_rdata   = win_val;
  assign peek_data   = peek_sel ? win_val : regs[A_STAT];
  assign own_id      = regs[A_OWN][2:0];

  assign xfer_wr_stb = dat_we && (lat_q == A_DATA);
  assign xfer_wdata  = dat_wdata;
  assign xfer_rd_stb = rd_take && (lat_q == A_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_stb  <= 1'b0;
      cmd_byte <= '0;
    end else begin
      cmd_stb <= dat_we && (lat_q == A_CMD);
      if (dat_we && (lat_q == A_CMD)) cmd_byte <= dat_wdata;
    end
  end
endmodule

// File: rtl/ixw_chk.sv
`timescale 1ns/1ps
module ixw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr_we,
  input logic [7:0] addr_wdata,
  input logic       dat_we,
  input logic       dat_re,
  input logic [7:0] dat_wdata,
  input logic [7:0] dat_rdata,
  input logic [4:0] lat,
  input logic [2:0] own_id,
  input logic       cmd_stb,
  input logic       xfer_rd_stb,
  input logic [7:0] xfer_rdata
);
  logic hold;
  assign hold = (lat == 5'h18) || (lat == 5'h19) || (lat == 5'h1F);

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> lat == $past(addr_wdata[4:0])); // R1
  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_we && dat_we && !hold) |=> lat == 5'($past(lat) + 5'd1)); // R2
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_we && dat_we && hold) |=> $stable(lat)); // R2
  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_we && !dat_we && dat_re && !hold) |=> lat == 5'($past(lat) + 5'd1)); // R3
  AST_OWN_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && lat == 5'h00) |=> own_id == $past(dat_wdata[2:0])); // R6
  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb || $past(dat_we && lat == 5'h18)); // R8
  AST_PASS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_rd_stb |-> dat_rdata == xfer_rdata); // R9
  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_we && !dat_we && !dat_re) |=> $stable(lat)); // R10
endmodule

bind ixw_top ixw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_wdata(addr_wdata),
  .dat_we(dat_we), .dat_re(dat_re), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
  .lat(lat_q), .own_id(own_id), .cmd_stb(cmd_stb),
  .xfer_rd_stb(xfer_rd_stb), .xfer_rdata(xfer_rdata)
);

// File: tb/tb_ixw_top.sv
`timescale 1ns/1ps
module tb_ixw_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        addr_we = 0;
  logic [7:0]  addr_wdata = 0;
  logic        dat_we = 0, dat_re = 0;
  logic [7:0]  dat_wdata = 0;
  logic [7:0]  dat_rdata;
  logic        peek_sel = 0;
  logic [7:0]  peek_data;
  logic [2:0]  own_id;
  logic [23:0] tc_value;
  logic        cmd_stb;
  logic [7:0]  cmd_byte;
  logic        xfer_wr_stb, xfer_rd_stb;
  logic [7:0]  xfer_wdata;
  logic [7:0]  xfer_rdata = 8'h5A;

  ixw_top dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_mem [32];
  logic [23:0] m_tc;
  logic [4:0]  m_lat;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit holds(input logic [4:0] a);
    return a == 5'h18 || a == 5'h19 || a == 5'h1F;
  endfunction

  function automatic logic [7:0] exp_val(input logic [4:0] a);
    if (a == 5'h12) return m_tc[23:16];
    if (a == 5'h13) return m_tc[15:8];
    if (a == 5'h14) return m_tc[7:0];
    if (a == 5'h19) return xfer_rdata;
    return m_mem[a];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++)
      m_mem[i] = (i == 31) ? 8'h80 : (i >= 27 && i <= 30) ? 8'hFF : 8'h00;
    m_tc = 0; m_lat = 0;
  endtask

  task automatic model_write(input logic [4:0] a, input logic [7:0] v);
    if (a == 5'h12) m_tc[23:16] = v;
    else if (a == 5'h13) m_tc[15:8] = v;
    else if (a == 5'h14) m_tc[7:0] = v;
    else if (a <= 5'h16) m_mem[a] = v;
  endtask

  task automatic peek_check(input string req);
    peek_sel = 1; #0.5;
    chk(peek_data == exp_val(m_lat), req, peek_data, exp_val(m_lat));
    peek_sel = 0; #0.5;
    chk(peek_data == 8'h80, "R10 status view", peek_data, 8'h80);
    chk(own_id == m_mem[0][2:0], "R6 own_id", own_id, m_mem[0][2:0]);
    chk(tc_value == m_tc, "R4 tc_value", tc_value, m_tc);
  endtask

  task automatic op_addr(input logic [7:0] v);
    @(negedge clk); addr_we = 1; addr_wdata = v;
    @(negedge clk); addr_we = 0;
    m_lat = v[4:0];
  endtask

  task automatic op_wr(input logic [7:0] v);
    logic [4:0] a;
    a = m_lat;
    @(negedge clk); dat_we = 1; dat_wdata = v; #1;
    chk(xfer_wr_stb == (a == 5'h19) && (a != 5'h19 || xfer_wdata == v), "R9 write pass",
        {xfer_wr_stb, xfer_wdata}, {(a == 5'h19), v});
    @(negedge clk); dat_we = 0;
    if (a == 5'h18) chk(cmd_stb && cmd_byte == v, "R8 cmd strobe", {cmd_stb, cmd_byte}, {1'b1, v});
    else chk(!cmd_stb, "R8 no cmd strobe", cmd_stb, 0);
    model_write(a, v);
    if (!holds(a)) m_lat = m_lat + 1;
  endtask

  task automatic op_rd(input logic [7:0] src);
    logic [4:0] a;
    a = m_lat;
    @(negedge clk); dat_re = 1; xfer_rdata = src; #1;
    chk(dat_rdata == exp_val(a), "R3 read data", dat_rdata, exp_val(a));
    chk(xfer_rd_stb == (a == 5'h19), "R9 read pass", xfer_rd_stb, (a == 5'h19));
    @(negedge clk); dat_re = 0;
    if (!holds(a)) m_lat = m_lat + 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D0C));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7 reset state
    chk(!cmd_stb && !xfer_wr_stb && !xfer_rd_stb, "R7 strobes idle", cmd_stb, 0);
    chk(own_id == 0 && tc_value == 0, "R7 id/count", {own_id, tc_value}, 0);
    for (int i = 0; i < 32; i++) begin
      op_addr(8'(i));
      peek_check("R7 reset value");
    end
    op_addr(8'h00);
    peek_check("R7 pointer after load");

    // R1 upper bits dropped
    op_addr(8'hE5); op_wr(8'h33);
    op_addr(8'h05); peek_check("R1 low bits");
    op_rd(8'h00);

    // R4 count lanes
    op_addr(8'h12); op_wr(8'h11); op_wr(8'h22); op_wr(8'h33);
    chk(tc_value == 24'h112233, "R4 assembled", tc_value, 24'h112233);
    op_addr(8'h13); op_wr(8'hA7);
    chk(tc_value == 24'h11A733, "R4 single lane", tc_value, 24'h11A733);
    op_addr(8'h12); op_rd(0); op_rd(0); op_rd(0);

    // R5 ignored writes
    op_addr(8'h17); op_wr(8'hC3); op_wr(8'hC3); op_wr(8'hC3);
    op_addr(8'h17); peek_check("R5 0x17 kept");
    op_addr(8'h1A); op_wr(8'h01); op_wr(8'h02); op_wr(8'h03); op_wr(8'h04); op_wr(8'h05);
    peek_check("R5 pointer parks at status");
    op_wr(8'h00); peek_check("R5 status write ignored");
    op_addr(8'h1B); peek_check("R5 fill kept");
    op_addr(8'h16); op_wr(8'h9E); op_addr(8'h16); peek_check("R5 0x16 stored");

    // R6 own id
    op_addr(8'h00); op_wr(8'hFE); peek_check("R6 id from write");

    // R8 command holds pointer, stores nothing
    op_addr(8'h18); op_wr(8'h09); op_wr(8'h06);
    @(negedge clk);
    chk(!cmd_stb, "R8 single cycle", cmd_stb, 0);
    peek_check("R8 cmd reg unchanged");
    op_rd(0); op_rd(0);

    // R9 data pass-through holds pointer
    op_addr(8'h19); op_wr(8'h77); op_rd(8'hC1); op_rd(8'h3E);
    peek_check("R9 data pointer held");

    // R1 address load with concurrent write: write lands at old pointer
    op_addr(8'h02);
    @(negedge clk); dat_we = 1; dat_wdata = 8'h4B; addr_we = 1; addr_wdata = 8'h08;
    @(negedge clk); dat_we = 0; addr_we = 0;
    model_write(5'h02, 8'h4B); m_lat = 5'h08;
    peek_check("R1 load beats step");
    op_addr(8'h02); peek_check("R1 write at old pointer");

    // R3 write beats read
    op_addr(8'h03);
    @(negedge clk); dat_we = 1; dat_re = 1; dat_wdata = 8'h6D; #1;
    chk(!xfer_rd_stb, "R3 read dropped", xfer_rd_stb, 0);
    @(negedge clk); dat_we = 0; dat_re = 0;
    model_write(5'h03, 8'h6D); m_lat = 5'h04;
    peek_check("R3 single step");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 2) op_addr(8'($urandom));
      else if (r < 6) op_wr(8'($urandom));
      else if (r < 9) op_rd(8'($urandom));
      else peek_check("R10 random peek");
    end
    peek_check("R10 final peek");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule